// File: doc/BRIEF.md
# BCD Clock and Calendar Timekeeper

This block keeps the time of day and a calendar as packed BCD bytes: seconds, minutes, hours, date, month, day of week and year. A tick input, typically a divided crystal pulse, is counted by a prescaler. After `TICKS_PER_SEC` pulses the time advances by one second. The carry then ripples through minutes, hours, date, month and year. Spare high bits carry the control flags. Bit 7 of the seconds byte halts timekeeping. Bit 7 of the hours byte selects the 12-hour format, in which bit 5 marks PM.

A serial front end reaches the registers through a simple parallel port. A 3-bit address selects a register. A write strobe stores a byte into it, and the read data for the addressed register is presented one cycle later. Writing the seconds register also restarts the sub-second prescaler, so software can set the time on a second boundary.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the registers read seconds 00 (running), minutes 00, hours 00 in 24-hour mode, date 01, month 01, day of week 01 and year 00.
- R2: Address 0 is seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week, 6 year. Address 7 always reads 00 and writes to it change nothing. `rd_data_o` shows the register addressed one clock earlier.
- R3: Bits with no meaning are stored as zero: minutes bit 7, hours bit 6, date bits 7:6, month bits 7:5 and day-of-week bits 7:3.
- R4: Seconds advance by one on every `TICKS_PER_SEC`-th tick pulse. A write to seconds clears the prescaler, and a write to any other register leaves it unchanged.
- R5: Seconds and minutes count 00 to 59 in BCD, with the tens digit in bits 6:4. Each wraps from 59 to 00 and carries into the next field.
- R6: While seconds bit 7 is 1, no register advances and tick pulses are not counted. Timekeeping resumes when the bit is written back to 0.
- R7: In 24-hour mode (hours bit 7 = 0), hours run 00 to 23 with tens in bits 5:4. The change from 23:59:59 to 00:00:00 advances the date.
- R8: In 12-hour mode (hours bit 7 = 1), hours run 01 to 12 in bits 4:0 and bit 5 = 1 marks PM. The change from 11:59:59 to 12:00:00 toggles bit 5. The change from 12 to 01 keeps bit 5. The date advances only on the step from 11:59:59 PM to 12:00:00 AM.
- R9: The date wraps to 01 after the last day of the month and advances the month. Months 04, 06, 09 and 11 have 30 days and February has 28 days. February has 29 days when the year value is divisible by 4. All other months have 31 days.
- R10: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00.
- R11: The day of week advances on every date change and wraps from 07 to 01.
- R12: If a write happens in the same cycle as a one-second step, the write is applied and the step is carried out on the next cycle. A write to seconds discards that step instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Sub-second tick pulse, one cycle wide |
| addr_i | input | 3 | Register address for read and write |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data of the register addressed in the previous cycle |

## Verification
The range assertions assume that every byte written through the port is a valid BCD value inside its field's range, with a month that is consistent with the written date. The counters would otherwise step through out-of-range codes until they wrap. The bench loads full timestamps only with legal values. The masking test writes set bits only in positions that are discarded, above in-range digits. Tick pulses are spaced one idle cycle apart, so the prescaler count the bench tracks matches the design.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    RA_SEC  = 3'd0,
    RA_MIN  = 3'd1,
    RA_HOUR = 3'd2,
    RA_DATE = 3'd3,
    RA_MON  = 3'd4,
    RA_DOW  = 3'd5,
    RA_YEAR = 3'd6,
    RA_NONE = 3'd7
  } rtc_addr_e;

  localparam logic [7:0] MASK_MIN  = 8'h7F;
  localparam logic [7:0] MASK_HOUR = 8'hBF;
  localparam logic [7:0] MASK_DATE = 8'h3F;
  localparam logic [7:0] MASK_MON  = 8'h1F;
  localparam logic [7:0] MASK_DOW  = 8'h07;

  // Next BCD value of a two-digit byte (no range wrap).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return {v[7:4], v[3:0] + 4'h1};
  endfunction

  // Last day of the month, as BCD.
  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    logic [6:0] ybin;
    ybin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    case (mon)
      8'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic run_i,
  input  logic clr_i,
  output logic step_o
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (tick_i && run_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign step_o = tick_i && run_i && !clr_i && (cnt_q == LAST);
endmodule

// File: rtl/rtc_time.sv
module rtc_time
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       adv_i,
  input  logic       wr_en_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic       day_o
);
  logic [7:0] sec_q, min_q, hour_q;
  logic [7:0] sec_inc, min_inc, hr_inc, hour_n;
  logic       sec_end, min_end, hr_end;

  assign sec_end = (sec_q[6:0] == 7'h59);
  assign min_end = (min_q == 8'h59);
  assign hr_end  = hour_q[7] ? (hour_q[5] && hour_q[4:0] == 5'h11)
                             : (hour_q[5:0] == 6'h23);
  assign day_o   = adv_i && sec_end && min_end && hr_end;

  always_comb begin
    sec_inc = bcd_inc({1'b0, sec_q[6:0]});
    min_inc = bcd_inc(min_q);
    hr_inc  = hour_q[7] ? bcd_inc({3'b000, hour_q[4:0]}) : bcd_inc({2'b00, hour_q[5:0]});
    if (hour_q[7]) begin
      if (hour_q[4:0] == 5'h12)      hour_n = {2'b10, hour_q[5], 5'h01};
      else if (hour_q[4:0] == 5'h11) hour_n = {2'b10, ~hour_q[5], 5'h12};
      else                           hour_n = {2'b10, hour_q[5], hr_inc[4:0]};
    end else begin
      hour_n = (hour_q[5:0] == 6'h23) ? 8'h00 : {2'b00, hr_inc[5:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else if (wr_en_i) begin
      case (addr_i)
        RA_SEC:  sec_q  <= wr_data_i;
        RA_MIN:  min_q  <= wr_data_i & MASK_MIN;
        RA_HOUR: hour_q <= wr_data_i & MASK_HOUR;
        default: ;
      endcase
    end else if (adv_i) begin
      sec_q <= sec_end ? {sec_q[7], 7'h00} : {sec_q[7], sec_inc[6:0]};
      if (sec_end) begin
        min_q <= min_end ? 8'h00 : min_inc;
        if (min_end) hour_q <= hour_n;
      end
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;
endmodule

// File: rtl/rtc_date.sv
module rtc_date
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       day_i,
  input  logic       wr_en_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] date_o,
  output logic [7:0] mon_o,
  output logic [7:0] dow_o,
  output logic [7:0] year_o
);
  logic [7:0] date_q, mon_q, dow_q, year_q;
  logic [7:0] last_day;
  logic       date_end, mon_end;

  assign last_day = month_len(mon_q, year_q);
  assign date_end = (date_q >= last_day);
  assign mon_end  = (mon_q == 8'h12);

  always_ff @(posedge clk) begin
    if (rst) begin
      date_q <= 8'h01;
      mon_q  <= 8'h01;
      dow_q  <= 8'h01;
      year_q <= 8'h00;
    end else if (wr_en_i) begin
      case (addr_i)
        RA_DATE: date_q <= wr_data_i & MASK_DATE;
        RA_MON:  mon_q  <= wr_data_i & MASK_MON;
        RA_DOW:  dow_q  <= wr_data_i & MASK_DOW;
        RA_YEAR: year_q <= wr_data_i;
        default: ;
      endcase
    end else if (day_i) begin
      dow_q  <= (dow_q == 8'h07) ? 8'h01 : dow_q + 8'h01;
      date_q <= date_end ? 8'h01 : bcd_inc(date_q);
      if (date_end) begin
        mon_q <= mon_end ? 8'h01 : bcd_inc(mon_q);
        if (mon_end) year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
      end
    end
  end

  assign date_o = date_q;
  assign mon_o  = mon_q;
  assign dow_o  = dow_q;
  assign year_o = year_q;
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic [2:0] addr_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o
);
  logic [7:0] sec_w, min_w, hour_w, date_w, mon_w, dow_w, year_w;
  logic       run, wr_sec, step_raw, pend_q, adv, day_step;

  assign run    = !sec_w[7];
  assign wr_sec = wr_en_i && (addr_i == RA_SEC);

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk(clk), .rst(rst), .tick_i(tick_i), .run_i(run), .clr_i(wr_sec), .step_o(step_raw)
  );

  // A step that collides with a write waits one cycle.
  assign adv = (step_raw || pend_q) && !wr_en_i && run;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= (step_raw || pend_q) && wr_en_i && !wr_sec;
  end

  rtc_time u_time (
    .clk(clk), .rst(rst), .adv_i(adv), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wr_data_i(wr_data_i), .sec_o(sec_w), .min_o(min_w), .hour_o(hour_w), .day_o(day_step)
  );

  rtc_date u_date (
    .clk(clk), .rst(rst), .day_i(day_step), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wr_data_i(wr_data_i), .date_o(date_w), .mon_o(mon_w), .dow_o(dow_w), .year_o(year_w)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= 8'h00;
    else begin
      case (addr_i)
        RA_SEC:  rd_data_o <= sec_w;
        RA_MIN:  rd_data_o <= min_w;
        RA_HOUR: rd_data_o <= hour_w;
        RA_DATE: rd_data_o <= date_w;
        RA_MON:  rd_data_o <= mon_w;
        RA_DOW:  rd_data_o <= dow_w;
        RA_YEAR: rd_data_o <= year_w;
        default: rd_data_o <= 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker (
  input logic       clk,
  input logic       rst,
  input logic       wr_en_i,
  input logic       step_raw,
  input logic       pend_q,
  input logic [7:0] sec_w,
  input logic [7:0] min_w,
  input logic [7:0] hour_w,
  input logic [7:0] date_w,
  input logic [7:0] mon_w,
  input logic [7:0] dow_w
);
  a_r3_unused_bits_zero: assert property (@(posedge clk) disable iff (rst)
    (min_w[7] == 1'b0 && hour_w[6] == 1'b0 && date_w[7:6] == 2'b00 &&
     mon_w[7:5] == 3'b000 && dow_w[7:3] == 5'b00000));

  a_r5_sec_min_range: assert property (@(posedge clk) disable iff (rst)
    (sec_w[6:0] <= 7'h59 && min_w <= 8'h59));

  a_r4_no_step_no_change: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && !step_raw && !pend_q) |=> $stable(sec_w));

  a_r6_halt_freezes: assert property (@(posedge clk) disable iff (rst)
    (sec_w[7] && !wr_en_i) |=> (sec_w == $past(sec_w) && min_w == $past(min_w) &&
                                hour_w == $past(hour_w) && date_w == $past(date_w)));

  a_r7_hour_24_range: assert property (@(posedge clk) disable iff (rst)
    !hour_w[7] |-> (hour_w[5:0] <= 6'h23));

  a_r8_hour_12_range: assert property (@(posedge clk) disable iff (rst)
    hour_w[7] |-> (hour_w[4:0] >= 5'h01 && hour_w[4:0] <= 5'h12));

  a_r11_dow_range: assert property (@(posedge clk) disable iff (rst)
    (dow_w >= 8'h01 && dow_w <= 8'h07));

  a_r10_month_range: assert property (@(posedge clk) disable iff (rst)
    (mon_w >= 8'h01 && mon_w <= 8'h12));
endmodule

bind bcd_rtc rtc_checker u_chk (
  .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .step_raw(step_raw), .pend_q(pend_q),
  .sec_w(sec_w), .min_w(min_w), .hour_w(hour_w), .date_w(date_w), .mon_w(mon_w), .dow_w(dow_w)
);

// File: tb/test_bcd_rtc.sv
`timescale 1ns/1ps
module test_bcd_rtc;
  localparam int TPS = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0;
  logic [2:0] addr_i = 3'd0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bcd_rtc #(.TICKS_PER_SEC(TPS)) i_bcd_rtc (
    .clk(clk), .rst(rst), .tick_i(tick_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    addr_i = a; wr_en_i = 1'b0;
    @(negedge clk);
    v = rd_data_o;
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  // Load a full timestamp; the seconds write comes last and clears the prescaler.
  task automatic load(input logic [7:0] s, m, h, d, mo, w, y);
    wr(3'd0, 8'h80);
    wr(3'd1, m); wr(3'd2, h); wr(3'd6, y); wr(3'd4, mo); wr(3'd3, d); wr(3'd5, w);
    wr(3'd0, s);
  endtask

  task automatic t_reset;
    expect_reg("R1 sec", 3'd0, 8'h00);
    expect_reg("R1 min", 3'd1, 8'h00);
    expect_reg("R1 hour", 3'd2, 8'h00);
    expect_reg("R1 date", 3'd3, 8'h01);
    expect_reg("R1 month", 3'd4, 8'h01);
    expect_reg("R1 dow", 3'd5, 8'h01);
    expect_reg("R1 year", 3'd6, 8'h00);
    expect_reg("R2 addr7 reads zero", 3'd7, 8'h00);
  endtask

  task automatic t_map_and_masks;
    load(8'h80, 8'hA7, 8'h52, 8'hD5, 8'hE9, 8'hFB, 8'h42);
    expect_reg("R3 min bit7 dropped", 3'd1, 8'h27);
    expect_reg("R3 hour bit6 dropped", 3'd2, 8'h12);
    expect_reg("R3 date bits7:6 dropped", 3'd3, 8'h15);
    expect_reg("R3 month bits7:5 dropped", 3'd4, 8'h09);
    expect_reg("R3 dow bits7:3 dropped", 3'd5, 8'h03);
    expect_reg("R2 year at addr6", 3'd6, 8'h42);
    wr(3'd7, 8'h5A);
    expect_reg("R2 addr7 write ignored", 3'd7, 8'h00);
    expect_reg("R2 addr7 write leaves sec", 3'd0, 8'h80);
    expect_reg("R2 addr7 write leaves year", 3'd6, 8'h42);
  endtask

  task automatic t_prescaler;
    load(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    ticks(TPS - 1);
    expect_reg("R4 no step before last tick", 3'd0, 8'h10);
    ticks(1);
    expect_reg("R4 step on last tick", 3'd0, 8'h11);
    ticks(2);
    wr(3'd0, 8'h20);
    ticks(TPS - 1);
    expect_reg("R4 sec write realigns", 3'd0, 8'h20);
    ticks(1);
    expect_reg("R4 step after realign", 3'd0, 8'h21);
    ticks(2);
    wr(3'd1, 8'h05);
    ticks(2);
    expect_reg("R4 other write keeps phase", 3'd0, 8'h22);
    expect_reg("R4 min written", 3'd1, 8'h05);
  endtask

  task automatic t_sec_min;
    load(8'h59, 8'h59, 8'h10, 8'h01, 8'h01, 8'h01, 8'h00);
    ticks(TPS);
    expect_reg("R5 sec wraps", 3'd0, 8'h00);
    expect_reg("R5 min wraps", 3'd1, 8'h00);
    expect_reg("R5 hour carried", 3'd2, 8'h11);
    load(8'h09, 8'h19, 8'h10, 8'h01, 8'h01, 8'h01, 8'h00);
    ticks(TPS);
    expect_reg("R5 sec BCD digit carry", 3'd0, 8'h10);
    expect_reg("R5 min untouched", 3'd1, 8'h19);
  endtask

  task automatic t_halt;
    load(8'hB3, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    ticks(3 * TPS);
    expect_reg("R6 halted sec frozen", 3'd0, 8'hB3);
    wr(3'd0, 8'h33);
    ticks(TPS);
    expect_reg("R6 resumes after clear", 3'd0, 8'h34);
  endtask

  task automatic t_24h;
    load(8'h59, 8'h59, 8'h23, 8'h05, 8'h03, 8'h03, 8'h21);
    ticks(TPS);
    expect_reg("R7 hour 23->00", 3'd2, 8'h00);
    expect_reg("R7 date advanced", 3'd3, 8'h06);
    expect_reg("R11 dow advanced", 3'd5, 8'h04);
    load(8'h59, 8'h59, 8'h09, 8'h05, 8'h03, 8'h03, 8'h21);
    ticks(TPS);
    expect_reg("R7 hour 09->10", 3'd2, 8'h10);
    expect_reg("R7 date held", 3'd3, 8'h05);
  endtask

  task automatic t_12h;
    load(8'h59, 8'h59, 8'h91, 8'h10, 8'h06, 8'h02, 8'h22);
    ticks(TPS);
    expect_reg("R8 11 AM -> 12 PM", 3'd2, 8'hB2);
    expect_reg("R8 noon keeps date", 3'd3, 8'h10);
    load(8'h59, 8'h59, 8'hB2, 8'h10, 8'h06, 8'h02, 8'h22);
    ticks(TPS);
    expect_reg("R8 12 PM -> 01 PM", 3'd2, 8'hA1);
    load(8'h59, 8'h59, 8'hB1, 8'h10, 8'h06, 8'h02, 8'h22);
    ticks(TPS);
    expect_reg("R8 11 PM -> 12 AM", 3'd2, 8'h92);
    expect_reg("R8 midnight advances date", 3'd3, 8'h11);
    load(8'h59, 8'h59, 8'h89, 8'h10, 8'h06, 8'h02, 8'h22);
    ticks(TPS);
    expect_reg("R8 09 AM -> 10 AM", 3'd2, 8'h90);
  endtask

  task automatic day_end(input logic [7:0] d, mo, w, y);
    load(8'h59, 8'h59, 8'h23, d, mo, w, y);
    ticks(TPS);
  endtask

  task automatic t_calendar;
    day_end(8'h31, 8'h01, 8'h07, 8'h23);
    expect_reg("R9 Jan 31 -> 01", 3'd3, 8'h01);
    expect_reg("R9 Jan -> Feb", 3'd4, 8'h02);
    expect_reg("R11 dow 07 -> 01", 3'd5, 8'h01);
    day_end(8'h28, 8'h02, 8'h01, 8'h23);
    expect_reg("R9 Feb 28 common year", 3'd3, 8'h01);
    expect_reg("R9 Feb -> Mar common", 3'd4, 8'h03);
    day_end(8'h28, 8'h02, 8'h01, 8'h24);
    expect_reg("R9 Feb 28 leap -> 29", 3'd3, 8'h29);
    expect_reg("R9 leap month held", 3'd4, 8'h02);
    day_end(8'h29, 8'h02, 8'h01, 8'h24);
    expect_reg("R9 Feb 29 leap -> 01", 3'd3, 8'h01);
    day_end(8'h30, 8'h04, 8'h01, 8'h24);
    expect_reg("R9 Apr 30 -> 01", 3'd3, 8'h01);
    expect_reg("R9 Apr -> May", 3'd4, 8'h05);
    day_end(8'h30, 8'h05, 8'h01, 8'h24);
    expect_reg("R9 May 30 -> 31", 3'd3, 8'h31);
    day_end(8'h31, 8'h12, 8'h05, 8'h99);
    expect_reg("R10 Dec -> Jan", 3'd4, 8'h01);
    expect_reg("R10 year 99 -> 00", 3'd6, 8'h00);
    day_end(8'h31, 8'h12, 8'h05, 8'h19);
    expect_reg("R10 year 19 -> 20", 3'd6, 8'h20);
  endtask

  task automatic t_collision;
    load(8'h30, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    ticks(TPS - 1);
    @(negedge clk);
    tick_i = 1'b1; wr_en_i = 1'b1; addr_i = 3'd1; wr_data_i = 8'h07;
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
    expect_reg("R12 deferred step applied", 3'd0, 8'h31);
    expect_reg("R12 colliding write applied", 3'd1, 8'h07);
    ticks(TPS - 1);
    @(negedge clk);
    tick_i = 1'b1; wr_en_i = 1'b1; addr_i = 3'd0; wr_data_i = 8'h40;
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
    expect_reg("R12 sec write discards step", 3'd0, 8'h40);
    ticks(TPS - 1);
    expect_reg("R12 phase restarted", 3'd0, 8'h40);
    ticks(1);
    expect_reg("R12 first step after", 3'd0, 8'h41);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_map_and_masks();
    t_prescaler();
    t_sec_min();
    t_halt();
    t_24h();
    t_12h();
    t_calendar();
    t_collision();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule